// File: doc/BRIEF.md
# MDIO Single-Command Management Engine

This block carries out one clause-22 management transaction at a time toward an external PHY. Software sets up a transaction with a single command word. That word carries the PHY and register addresses, a read or write opcode bit, and a start bit. The engine then produces the management clock and the serial frame by itself. Software polls the start bit, which reads back as busy until the frame has finished. After a read it collects the returned halfword from the upper half of the data register, and a status bit that says whether the PHY answered.

The management clock is divided down from the system clock by a parameter. It runs only while a transaction is in progress. The engine changes the bit it drives on the falling edge of the management clock and samples the PHY on the rising edge. A frame is 64 bit-times long: 32 preamble ones, the start pattern 01, the opcode (10 for a read, 01 for a write), the 5-bit PHY address and the 5-bit register address (both most significant bit first), two turnaround bit-times, and 16 data bits.

The controller is a five-state machine:
- IDLE goes to PREAMBLE when a command is accepted.
- PREAMBLE goes to HEADER after bit 31.
- HEADER goes to TURN after bit 45.
- TURN goes to DATA after bit 47.
- DATA goes back to IDLE at the falling edge that ends bit 63.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the busy bit, `mdc` and `mdio_oe` are 0, and the command, data and status registers all read as 0.
- R2: A write to the command register (`reg_sel` = 0) is accepted only when bit 20 (start) is 1, at least one of bit 17 (read) or bit 16 (write) is 1, and the engine is idle. If both opcode bits are set, the read bit wins. The command register reads back busy in bit 20, the recorded read and write opcode bits in bits 17 and 16, the PHY address in bits 12:8 and the register address in bits 4:0. Busy reads 1 from the cycle after the accepting edge.
- R3: While busy, `mdc` starts low and toggles every DIV_HALF system clocks. While idle it stays low.
- R4: A frame drives 32 ones, then 0 and 1, then the opcode (1,0 for a read; 0,1 for a write), then the PHY address and the register address, each most significant bit first.
- R5: In a write, `mdio_oe` is high for all 64 bit-times. The turnaround is driven as 1 then 0. The data bits are data-register bits 15:0 as they stood at acceptance, most significant bit first.
- R6: In a read, `mdio_oe` is low for the turnaround and the data bit-times. `mdio_i` is sampled at each rising `mdc` edge of the data bits. The 16 sampled bits land in data-register bits 31:16 at completion.
- R7: Status bit 0 (`reg_sel` = 2) takes, at the end of each read, the value sampled on the second turnaround bit: 1 means the PHY did not respond. Writes leave it unchanged.
- R8: Busy clears at the system-clock edge that carries the falling `mdc` edge ending bit 63, which is 128×DIV_HALF cycles after acceptance.
- R9: A command write made while busy, or without the start bit, or without either opcode bit, changes neither the command register nor the bus.
- R10: If a data-register write (`reg_sel` = 1) lands on the same edge that completes a read, bits 31:16 take the read result and bits 15:0 take the written value.
- R11: Driven data changes only at falling `mdc` edges, or when the bus leaves idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 data, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read value of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Two events can fall in the same cycle: the completion of a read and a software write. The bench places a data-register write on exactly the edge that ends bit 63 of a read. It judges that the upper half holds the PHY's halfword and the lower half holds the written value. It also places a command write on that same completion edge, and checks that the command is dropped because busy is still set there. A command issued on the very next cycle starts a fresh frame. A behavioural reference model checks the bus, the busy bit and the selected register on every clock.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

    localparam int CMD_GO_BIT  = 20;
    localparam int CMD_RD_BIT  = 17;
    localparam int CMD_WR_BIT  = 16;
    localparam int CMD_PHY_LSB = 8;
    localparam int RD_HALF_LSB = 16;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = (cnt == CW'(DIV_HALF - 1));
    assign rise_evt = run && wrap && !mdc;
    assign fall_evt = run && wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (restart || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    // R3
    mdc_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != $past(mdc)) |-> $past(wrap));
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_eng_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              no_resp
);
    localparam int HDR_BITS = 4 + 2 * ADDR_W;
    localparam int HDR_END  = PRE_BITS + HDR_BITS;
    localparam int TA_END   = HDR_END + 2;
    localparam int FRAME    = TA_END + DATA_W;
    localparam int IW       = $clog2(FRAME);

    mdio_state_e       state, state_nx;
    logic [IW-1:0]     bit_idx;
    logic [IW-1:0]     pos;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_shift;
    logic              ta_seen;
    logic [FRAME-1:0]  frame_vec;

    assign busy = (state != ST_IDLE);
    assign done = fall_evt && (state == ST_DATA) && (bit_idx == IW'(FRAME - 1));
    assign pos  = IW'(FRAME - 1) - bit_idx;

    assign frame_vec = {{PRE_BITS{1'b1}}, 2'b01,
                        (is_read ? 2'b10 : 2'b01),
                        phy_addr, reg_addr,
                        (is_read ? 2'b00 : 2'b10),
                        (is_read ? {DATA_W{1'b0}} : wd_q)};

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (launch) state_nx = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_evt && bit_idx == IW'(PRE_BITS - 1)) state_nx = ST_HEADER;
            ST_HEADER:   if (fall_evt && bit_idx == IW'(HDR_END - 1))  state_nx = ST_TURN;
            ST_TURN:     if (fall_evt && bit_idx == IW'(TA_END - 1))   state_nx = ST_DATA;
            ST_DATA:     if (done) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
        end else begin
            state <= state_nx;
            if (launch || done)
                bit_idx <= '0;
            else if (fall_evt)
                bit_idx <= bit_idx + 1'b1;
        end
    end

    // write-data hold and read sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q     <= '0;
            rd_shift <= '0;
            ta_seen  <= 1'b0;
        end else if (launch) begin
            wd_q     <= wdata;
            rd_shift <= '0;
            ta_seen  <= 1'b0;
        end else if (rise_evt && is_read) begin
            if (state == ST_TURN && bit_idx == IW'(TA_END - 1))
                ta_seen <= mdio_i;
            if (state == ST_DATA)
                rd_shift <= {rd_shift[DATA_W-2:0], mdio_i};
        end
    end

    assign rdata   = rd_shift;
    assign no_resp = ta_seen;

    // output logic
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
            ST_PREAMBLE, ST_HEADER: begin
                mdio_o  = frame_vec[pos];
                mdio_oe = 1'b1;
            end
            ST_TURN, ST_DATA: begin
                mdio_o  = is_read ? 1'b0 : frame_vec[pos];
                mdio_oe = !is_read;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end

    // R11
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $past(fall_evt));

    // R8
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R5
    write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_read) |-> mdio_oe);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_eng_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int PRE_BITS = 32,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy;
    logic              done;
    logic              launch;
    logic              rise_evt;
    logic              fall_evt;
    logic              rd_q;
    logic              wr_q;
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] reg_q;
    logic [31:0]       data_q;
    logic              stat_q;
    logic [DATA_W-1:0] rd_word;
    logic              no_resp;

    assign launch = reg_we && (reg_sel == SEL_CMD) && !busy
                    && reg_wdata[CMD_GO_BIT]
                    && (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);

    // command fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            phy_q <= '0;
            reg_q <= '0;
        end else if (launch) begin
            rd_q  <= reg_wdata[CMD_RD_BIT];
            wr_q  <= !reg_wdata[CMD_RD_BIT];
            phy_q <= reg_wdata[CMD_PHY_LSB +: ADDR_W];
            reg_q <= reg_wdata[0 +: ADDR_W];
        end
    end

    // data and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            stat_q <= 1'b0;
        end else begin
            if (reg_we && reg_sel == SEL_DATA)
                data_q <= reg_wdata;
            if (done && rd_q) begin
                data_q[RD_HALF_LSB +: DATA_W] <= rd_word;
                stat_q <= no_resp;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CMD: begin
                reg_rdata[CMD_GO_BIT]             = busy;
                reg_rdata[CMD_RD_BIT]             = rd_q;
                reg_rdata[CMD_WR_BIT]             = wr_q;
                reg_rdata[CMD_PHY_LSB +: ADDR_W]  = phy_q;
                reg_rdata[0 +: ADDR_W]            = reg_q;
            end
            SEL_DATA: reg_rdata = data_q;
            SEL_STAT: reg_rdata[0] = stat_q;
            default:  reg_rdata = '0;
        endcase
    end

    mdio_clk_gen #(
        .DIV_HALF (DIV_HALF)
    ) i_clk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .restart  (launch),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_fsm #(
        .PRE_BITS (PRE_BITS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) i_frame_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .is_read  (rd_q),
        .phy_addr (phy_q),
        .reg_addr (reg_q),
        .wdata    (data_q[DATA_W-1:0]),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rdata    (rd_word),
        .no_resp  (no_resp)
    );

    // R9
    busy_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && reg_sel == SEL_CMD));

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(phy_q) && $stable(reg_q) && $stable(rd_q)));

    // R7
    status_on_read_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q != $past(stat_q)) |-> $past(done && rd_q));
endmodule

// File: tb/test_mdio_cmd_engine.sv
module test_mdio_cmd_engine;
    localparam int H  = 4;
    localparam int FR = 64;
    localparam int TOTAL = FR * 2 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    string cur = "R1";

    // reference model state
    logic        m_busy = 0;
    int          m_k = 0;
    logic        m_rd = 0, m_wr = 0;
    logic [4:0]  m_phy = 0, m_reg = 0;
    logic [31:0] m_data = 0;
    logic [15:0] m_wd = 0;
    logic        m_stat = 0;
    logic [15:0] resp_data = 16'hFFFF;
    logic        resp_ta = 1'b1;

    always #5 clk = ~clk;

    mdio_cmd_engine #(.DIV_HALF(H)) i_mdio_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h at %0t", req, cur, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_bit(int b);
        if (b < 32) return 2'b11;
        if (b < 34) return {1'b1, b == 33};
        if (b < 36) return {1'b1, m_rd ? (b == 34) : (b == 35)};
        if (b < 41) return {1'b1, m_phy[4 - (b - 36)]};
        if (b < 46) return {1'b1, m_reg[4 - (b - 41)]};
        if (m_rd) return 2'b00;
        if (b < 48) return {1'b1, b == 46};
        return {1'b1, m_wd[15 - (b - 48)]};
    endfunction

    function automatic logic [31:0] mk_cmd(bit go, bit rd, bit wr, logic [4:0] phy, logic [4:0] rg);
        return (32'(go) << 20) | (32'(rd) << 17) | (32'(wr) << 16) | (32'(phy) << 8) | 32'(rg);
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        logic done;
        logic old_busy;
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_rd = 0; m_wr = 0; m_phy = 0; m_reg = 0;
            m_data = 0; m_stat = 0; m_wd = 0;
        end else begin
            old_busy = m_busy;
            done = m_busy && (m_k == TOTAL - 1);
            if (m_busy) begin
                if (done) begin m_busy = 0; m_k = 0; end
                else m_k++;
            end
            if (reg_we && reg_sel == 2'd0 && !old_busy && reg_wdata[20]
                && (reg_wdata[17] || reg_wdata[16])) begin
                m_rd = reg_wdata[17]; m_wr = !reg_wdata[17];
                m_phy = reg_wdata[12:8]; m_reg = reg_wdata[4:0];
                m_wd = m_data[15:0];
                m_busy = 1; m_k = 0;
            end
            if (reg_we && reg_sel == 2'd1) m_data = reg_wdata;
            if (done && m_rd) begin
                m_data[31:16] = resp_data;
                m_stat = resp_ta;
            end
        end
    end

    // per-cycle comparison and PHY drive, away from the clock edge
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            int b;
            logic [1:0] eb;
            logic [31:0] er;
            b = m_k / (2 * H);
            eb = m_busy ? exp_bit(b) : 2'b00;
            chk("R3 mdc", 32'(mdc), m_busy ? 32'((m_k / H) % 2) : 0);
            chk(b < 36 ? "R4 R11 oe" : (m_rd ? "R6 oe" : "R5 oe"), 32'(mdio_oe), 32'(eb[1]));
            chk(b < 36 ? "R4 R11 out" : (m_rd ? "R6 out" : "R5 out"), 32'(mdio_o), 32'(eb[0]));
            case (reg_sel)
                2'd0: er = {11'b0, m_busy, 2'b0, m_rd, m_wr, 3'b0, m_phy, 3'b0, m_reg};
                2'd1: er = m_data;
                2'd2: er = {31'b0, m_stat};
                default: er = 0;
            endcase
            chk(reg_sel == 0 ? "R2 R8 cmd" : (reg_sel == 1 ? "R6 R10 data" : "R7 status"),
                reg_rdata, er);
            if (m_busy && m_rd)
                mdio_i = (b == 47) ? resp_ta : (b >= 48 ? resp_data[15 - (b - 48)] : 1'b1);
            else
                mdio_i = 1'b1;
        end
    end

    task automatic put(logic [1:0] sel, logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
    endtask

    task automatic wait_last();
        while (!(m_busy && m_k == TOTAL - 1)) @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired [%s]", cur);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur = "R1";
        for (int s = 0; s < 3; s++) begin
            reg_sel = 2'(s);
            repeat (2) @(negedge clk);
        end
        // write transaction
        cur = "R5";
        @(negedge clk); put(2'd1, 32'h0000A5C3);
        put(2'd0, mk_cmd(1, 0, 1, 5'h05, 5'h1A));
        reg_sel = 2'd0;
        repeat (100) @(negedge clk);
        cur = "R9";
        put(2'd0, mk_cmd(1, 1, 0, 5'h1F, 5'h01));
        wait_idle();
        // read transaction with response
        cur = "R6";
        resp_data = 16'hBEEF; resp_ta = 1'b0;
        put(2'd0, mk_cmd(1, 1, 0, 5'h11, 5'h03));
        reg_sel = 2'd1;
        wait_idle();
        reg_sel = 2'd2; repeat (2) @(negedge clk);
        // read with no PHY response
        cur = "R7";
        resp_data = 16'hFFFF; resp_ta = 1'b1;
        put(2'd0, mk_cmd(1, 1, 0, 5'h0A, 5'h15));
        wait_idle();
        reg_sel = 2'd1; repeat (2) @(negedge clk);
        // ignored commands
        cur = "R9";
        reg_sel = 2'd0;
        put(2'd0, mk_cmd(0, 1, 0, 5'h03, 5'h03));
        put(2'd0, mk_cmd(1, 0, 0, 5'h03, 5'h03));
        repeat (4) @(negedge clk);
        // both opcode bits: read wins
        cur = "R2";
        resp_data = 16'h1234; resp_ta = 1'b0;
        put(2'd0, mk_cmd(1, 1, 1, 5'h16, 5'h09));
        wait_idle();
        // data write colliding with read completion
        cur = "R10";
        resp_data = 16'h5A0F; resp_ta = 1'b0;
        put(2'd0, mk_cmd(1, 1, 0, 5'h01, 5'h02));
        reg_sel = 2'd1;
        wait_last();
        put(2'd1, 32'hCAFE7711);
        repeat (2) @(negedge clk);
        // command on the completion edge is dropped, next cycle accepted
        cur = "R9 R8";
        resp_data = 16'h0F0F; resp_ta = 1'b1;
        put(2'd0, mk_cmd(1, 1, 0, 5'h02, 5'h04));
        reg_sel = 2'd0;
        wait_last();
        put(2'd0, mk_cmd(1, 0, 1, 5'h1C, 5'h1C));
        put(2'd0, mk_cmd(1, 0, 1, 5'h13, 5'h0E));
        wait_idle();
        reg_sel = 2'd2; repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule